// File: doc/BRIEF.md
# Mode-Programmed Burst Column Sequencer

This block turns a programmed memory mode word into a stream of column addresses. Software-visible configuration arrives as a load strobe with a data word, aimed either at the base mode register or at the extended mode register. From the base word the block takes the burst length, the beat order and the read latency, plus a DLL-reset request. From the extended word it takes the DLL enable. A load whose length or latency code is illegal is refused as a whole and raises an error flag.

A command side starts bursts with a pulse, a starting column and a read/write flag. While a burst runs, the block presents one column per clock. Only the low log2(length) bits move. The upper bits hold the starting value. A terminate pulse cuts a read short. A fresh start during a burst restarts the count at the new column.

The controller has three states. IDLE waits for a start. READ and WRITE step the beat counter. The transitions are:

- START: IDLE, READ or WRITE go to READ or WRITE on a start pulse, according to the read/write flag. The beat resets to 0.
- STEP: READ or WRITE stay in their state while the beat is below the last one.
- DONE: READ or WRITE go to IDLE after the last beat.
- TERM: READ goes to IDLE on a terminate pulse.

Top module: `burst_col_seq`

## Requirements
- R1: A base load with length code bits [2:0] of 001, 010 or 011 sets the burst length to 2, 4 or 8 beats respectively.
- R2: A base load whose length code is outside {001,010,011}, or whose latency code is outside {010,110}, sets `cfg_error` to 1. Such a load leaves every decoded setting unchanged. A later legal base load clears `cfg_error`.
- R3: Base bit 3 selects the beat order: 0 is sequential, 1 is interleaved.
- R4: Latency code bits [6:4] of 010 give `cas_lat` = 2 and 110 give `cas_lat` = 3. `cas_lat` is never any other value.
- R5: `dll_reset` equals bit 8 of the last accepted base load.
- R6: `dll_enable` is the inverse of bit 0 of the last extended load.
- R7: After a clock edge with `burst_start` high, `burst_active` is 1 and `col_out` equals the sampled `start_col`. The beat index then rises by one per clock.
- R8: During a burst of length L, the bits of `col_out` above log2(L) equal those of the start column. The low bits are (start_low + beat) mod L in sequential order and start_low XOR beat in interleaved order.
- R9: `last_beat` is 1 exactly on beat L-1. Without a new start, `burst_active` is 0 on the next clock.
- R10: `burst_stop` during a read burst makes `burst_active` 0 on the next clock. During a write burst it has no effect.
- R11: A start during an active burst restarts at beat 0 from the new column and with the new direction. A start takes priority over a stop in the same cycle.
- R12: After reset the block is idle, with length 2, sequential order, `cas_lat` = 2, `dll_reset` = 0, `dll_enable` = 1 and `cfg_error` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register load strobe |
| mode_sel | input | 1 | 0 selects the base register, 1 selects the extended register |
| mode_data | input | MR_W | Mode word being loaded |
| burst_start | input | 1 | Starts a burst at `start_col` |
| burst_is_write | input | 1 | Direction of the started burst (1 = write) |
| start_col | input | COL_W | Starting column |
| burst_stop | input | 1 | Burst terminate (acts on reads only) |
| col_out | output | COL_W | Current column, 0 when idle |
| burst_active | output | 1 | A burst beat is being presented |
| last_beat | output | 1 | The current beat is the final one |
| cas_lat | output | 2 | Decoded read latency |
| dll_reset | output | 1 | DLL reset requested |
| dll_enable | output | 1 | DLL enabled |
| cfg_error | output | 1 | The last base load carried an illegal code |

## Verification
The assertions assume that `mode_wr`, `burst_start` and `burst_stop` are driven to known values from reset onward. They also assume that `start_col` is stable at the edge where a start is sampled. The column checks further rely on the length field never exceeding the beat counter width, which the load rejection guarantees. The stimulus changes every input one time unit after a rising edge and holds strobes low through reset. It programs only through the load strobe, so each burst runs under a configuration that passed the legality check.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } beat_order_e;

    typedef struct packed {
        logic [1:0]  len_log2;
        beat_order_e order;
        logic        cas3;
        logic        dll_rst;
        logic        dll_dis;
    } mode_cfg_t;

    localparam logic [2:0] CL_CODE_2 = 3'b010;
    localparam logic [2:0] CL_CODE_3 = 3'b110;

    function automatic logic len_code_ok(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
    endfunction

    function automatic logic cl_code_ok(input logic [2:0] code);
        return (code == CL_CODE_2) || (code == CL_CODE_3);
    endfunction

endpackage

// File: rtl/mode_decoder.sv
module mode_decoder
    import burst_seq_pkg::*;
#(
    parameter int MR_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_wr,
    input  logic            mode_sel,
    input  logic [MR_W-1:0] mode_data,
    output mode_cfg_t       cfg,
    output logic            cfg_error
);

    localparam int LEN_LSB = 0;
    localparam int ORD_BIT = 3;
    localparam int CL_LSB  = 4;
    localparam int DLLR_BIT = 8;
    localparam int DLLD_BIT = 0;

    logic [2:0] len_code;
    logic [2:0] cl_code;
    logic       load_ok;
    logic       unused_bits;

    assign len_code    = mode_data[LEN_LSB +: 3];
    assign cl_code     = mode_data[CL_LSB +: 3];
    assign load_ok     = len_code_ok(len_code) && cl_code_ok(cl_code);
    assign unused_bits = ^{mode_data[MR_W-1:DLLR_BIT+1], mode_data[7]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.len_log2 <= 2'd1;
            cfg.order    <= ORD_SEQ;
            cfg.cas3     <= 1'b0;
            cfg.dll_rst  <= 1'b0;
            cfg.dll_dis  <= 1'b0;
            cfg_error    <= 1'b0;
        end else if (mode_wr) begin
            if (mode_sel) begin
                cfg.dll_dis <= mode_data[DLLD_BIT];
            end else if (load_ok) begin
                cfg.len_log2 <= len_code[1:0];
                cfg.order    <= beat_order_e'(mode_data[ORD_BIT]);
                cfg.cas3     <= cl_code[2];
                cfg.dll_rst  <= mode_data[DLLR_BIT];
                cfg_error    <= 1'b0;
            end else begin
                cfg_error    <= 1'b1;
            end
        end
    end

    // R2: a refused base load changes no decoded setting
    assert_illegal_keeps_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !mode_sel && !load_ok) |=> (cfg_error && $stable(cfg)));

    // R6: an extended load touches only the DLL disable bit
    assert_ext_only_dll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_sel) |=> ($stable(cfg.len_log2) && $stable(cfg.cas3)
                                   && $stable(cfg_error)));

endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic              burst_is_write,
    input  logic              burst_stop,
    input  logic [1:0]        len_log2,
    output logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] beat_mask,
    output logic              active,
    output logic              last
);

    seq_state_e        state_q, state_d;
    logic [1:0]        len_q;
    logic [BEAT_W-1:0] beat_q;
    logic              at_last;
    seq_state_e        start_target;

    assign start_target = burst_is_write ? ST_WRITE : ST_READ;
    assign beat_mask    = ~({BEAT_W{1'b1}} << len_q);
    assign at_last      = (beat_q == beat_mask);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (burst_start) state_d = start_target;
            end
            ST_READ: begin
                if (burst_start)      state_d = start_target;
                else if (burst_stop)  state_d = ST_IDLE;
                else if (at_last)     state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (burst_start)      state_d = start_target;
                else if (at_last)     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register with beat counter and captured length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            len_q   <= 2'd1;
        end else begin
            state_q <= state_d;
            if (burst_start) begin
                beat_q <= '0;
                len_q  <= len_log2;
            end else if (state_d != ST_IDLE) begin
                beat_q <= beat_q + 1'b1;
            end else begin
                beat_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        active = (state_q != ST_IDLE);
        last   = active && at_last;
        beat   = beat_q;
    end

    // R10: terminate during a read ends the burst on the next clock
    assert_stop_read_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && burst_stop && !burst_start) |=> (state_q == ST_IDLE));

    // R10: terminate is ignored during a write that is not on its last beat
    assert_stop_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && burst_stop && !burst_start && !at_last)
            |=> (state_q == ST_WRITE));

    // R11: a start always resets the beat index
    assert_restart_beat_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> (beat_q == '0));

endmodule

// File: rtl/col_gen.sv
module col_gen
    import burst_seq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic [COL_W-1:0]  start_col,
    input  beat_order_e       order,
    input  logic [BEAT_W-1:0] beat,
    input  logic [BEAT_W-1:0] beat_mask,
    input  logic              active,
    output logic [COL_W-1:0]  col_out
);

    localparam int HI_W = COL_W - BEAT_W;

    logic [COL_W-1:0]  base_q;
    beat_order_e       order_q;
    logic [BEAT_W-1:0] base_low;
    logic [BEAT_W-1:0] moved_low;
    logic [BEAT_W-1:0] next_low;
    logic [COL_W-1:0]  col_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_SEQ;
        end else if (burst_start) begin
            base_q  <= start_col;
            order_q <= order;
        end
    end

    assign base_low = base_q[BEAT_W-1:0];

    always_comb begin
        unique case (order_q)
            ORD_SEQ:   moved_low = (base_low + beat) & beat_mask;
            ORD_INTLV: moved_low = (base_low ^ beat) & beat_mask;
            default:   moved_low = base_low & beat_mask;
        endcase
        next_low = (base_low & ~beat_mask) | moved_low;
        col_full = {base_q[COL_W-1 -: HI_W], next_low};
        col_out  = active ? col_full : '0;
    end

    // R8: bits above the burst window hold through a burst
    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !burst_start) |=>
            (!active || ((col_out & ~{{HI_W{1'b0}}, beat_mask})
                         == $past(col_out & ~{{HI_W{1'b0}}, beat_mask}))));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int MR_W   = 13,
    parameter int COL_W  = 10,
    parameter int BEAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             mode_sel,
    input  logic [MR_W-1:0]  mode_data,
    input  logic             burst_start,
    input  logic             burst_is_write,
    input  logic [COL_W-1:0] start_col,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_out,
    output logic             burst_active,
    output logic             last_beat,
    output logic [1:0]       cas_lat,
    output logic             dll_reset,
    output logic             dll_enable,
    output logic             cfg_error
);

    mode_cfg_t         cfg;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] beat_mask;

    mode_decoder #(.MR_W(MR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mode_sel  (mode_sel),
        .mode_data (mode_data),
        .cfg       (cfg),
        .cfg_error (cfg_error)
    );

    burst_fsm #(.BEAT_W(BEAT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .burst_start    (burst_start),
        .burst_is_write (burst_is_write),
        .burst_stop     (burst_stop),
        .len_log2       (cfg.len_log2),
        .beat           (beat),
        .beat_mask      (beat_mask),
        .active         (burst_active),
        .last           (last_beat)
    );

    col_gen #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_start (burst_start),
        .start_col   (start_col),
        .order       (cfg.order),
        .beat        (beat),
        .beat_mask   (beat_mask),
        .active      (burst_active),
        .col_out     (col_out)
    );

    assign cas_lat    = cfg.cas3 ? 2'd3 : 2'd2;
    assign dll_reset  = cfg.dll_rst;
    assign dll_enable = !cfg.dll_dis;

    // R7: a start shows beat 0 at the requested column on the next clock
    assert_start_loads_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> (burst_active && col_out == $past(start_col)));

    // R9: the burst ends right after its last beat
    assert_last_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !burst_start) |=> !burst_active);

    // R4: latency only takes legal values
    assert_cas_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat == 2'd2) || (cas_lat == 2'd3));

    // R9: last beat only inside a burst
    assert_last_in_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> burst_active);

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MR_W  = 13;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             mode_wr;
    logic             mode_sel;
    logic [MR_W-1:0]  mode_data;
    logic             burst_start;
    logic             burst_is_write;
    logic [COL_W-1:0] start_col;
    logic             burst_stop;
    logic [COL_W-1:0] col_out;
    logic             burst_active;
    logic             last_beat;
    logic [1:0]       cas_lat;
    logic             dll_reset;
    logic             dll_enable;
    logic             cfg_error;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    burst_col_seq #(.MR_W(MR_W), .COL_W(COL_W), .BEAT_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
        .mode_data(mode_data), .burst_start(burst_start),
        .burst_is_write(burst_is_write), .start_col(start_col),
        .burst_stop(burst_stop), .col_out(col_out), .burst_active(burst_active),
        .last_beat(last_beat), .cas_lat(cas_lat), .dll_reset(dll_reset),
        .dll_enable(dll_enable), .cfg_error(cfg_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [MR_W-1:0] mw(input logic [2:0] bl, input logic ord,
                                           input logic [2:0] cl, input logic dr);
        return {4'b0, dr, 1'b0, cl, ord, bl};
    endfunction

    function automatic int exp_col(input int base, input int len, input bit ord, input int i);
        int low;
        low = ord ? ((base % len) ^ i) : (((base % len) + i) % len);
        return (base - (base % len)) + low;
    endfunction

    task automatic load(input bit sel, input logic [MR_W-1:0] d);
        mode_wr = 1; mode_sel = sel; mode_data = d;
        tick();
        mode_wr = 0;
    endtask

    task automatic run_burst(input int col, input bit wr, input int len, input bit ord,
                             input bit hold_stop, input string req);
        burst_start = 1; burst_is_write = wr; start_col = COL_W'(col);
        tick();
        burst_start = 0; burst_stop = hold_stop;
        for (int i = 0; i < len; i++) begin
            chk(burst_active == 1, req, "active", burst_active, 1);
            chk(int'(col_out) == exp_col(col, len, ord, i), req, "col", col_out,
                exp_col(col, len, ord, i));
            chk(last_beat == (i == len-1), req, "last", last_beat, i == len-1);
            tick();
        end
        burst_stop = 0;
        chk(burst_active == 0, "R9", "idle after burst", burst_active, 0);
    endtask

    task automatic t_reset();
        chk(burst_active == 0, "R12", "active", burst_active, 0);
        chk(cas_lat == 2, "R12", "cas", cas_lat, 2);
        chk(dll_reset == 0, "R12", "dll_reset", dll_reset, 0);
        chk(dll_enable == 1, "R12", "dll_enable", dll_enable, 1);
        chk(cfg_error == 0, "R12", "error", cfg_error, 0);
        chk(col_out == 0, "R12", "col", col_out, 0);
        run_burst(5, 0, 2, 0, 0, "R12");
    endtask

    task automatic t_lengths();
        load(0, mw(3'b001, 0, 3'b010, 0)); run_burst(13, 0, 2, 0, 0, "R1");
        load(0, mw(3'b010, 0, 3'b010, 0)); run_burst(14, 1, 4, 0, 0, "R1");
        load(0, mw(3'b011, 0, 3'b010, 0)); run_burst(11, 0, 8, 0, 0, "R1");
    endtask

    task automatic t_order();
        load(0, mw(3'b011, 1, 3'b010, 0)); run_burst(10'h2B5, 0, 8, 1, 0, "R3");
        load(0, mw(3'b010, 1, 3'b010, 0)); run_burst(10'h17, 1, 4, 1, 0, "R8");
        load(0, mw(3'b011, 0, 3'b010, 0)); run_burst(10'h3FE, 1, 8, 0, 0, "R8");
    endtask

    task automatic t_cas_dll();
        load(0, mw(3'b010, 0, 3'b110, 1));
        chk(cas_lat == 3, "R4", "cas 3", cas_lat, 3);
        chk(dll_reset == 1, "R5", "dll_reset set", dll_reset, 1);
        load(0, mw(3'b010, 0, 3'b010, 0));
        chk(cas_lat == 2, "R4", "cas 2", cas_lat, 2);
        chk(dll_reset == 0, "R5", "dll_reset clear", dll_reset, 0);
        load(1, 13'h1);
        chk(dll_enable == 0, "R6", "dll off", dll_enable, 0);
        chk(cas_lat == 2, "R6", "ext keeps cas", cas_lat, 2);
        load(1, 13'h0);
        chk(dll_enable == 1, "R6", "dll on", dll_enable, 1);
    endtask

    task automatic t_illegal();
        load(0, mw(3'b010, 1, 3'b110, 0));
        chk(cfg_error == 0, "R2", "legal", cfg_error, 0);
        load(0, mw(3'b111, 0, 3'b010, 1));
        chk(cfg_error == 1, "R2", "bad len", cfg_error, 1);
        chk(cas_lat == 3, "R2", "cas kept", cas_lat, 3);
        chk(dll_reset == 0, "R2", "dll kept", dll_reset, 0);
        load(0, mw(3'b011, 0, 3'b011, 0));
        chk(cfg_error == 1, "R2", "bad cl", cfg_error, 1);
        run_burst(9, 0, 4, 1, 0, "R2");
        load(0, mw(3'b011, 0, 3'b010, 0));
        chk(cfg_error == 0, "R2", "cleared", cfg_error, 0);
    endtask

    task automatic t_stop();
        load(0, mw(3'b011, 0, 3'b010, 0));
        burst_start = 1; burst_is_write = 0; start_col = 10'h40;
        tick(); burst_start = 0;
        tick();
        burst_stop = 1;
        tick();
        burst_stop = 0;
        chk(burst_active == 0, "R10", "read stopped", burst_active, 0);
        chk(col_out == 0, "R10", "col idle", col_out, 0);
        run_burst(10'h44, 1, 8, 0, 1, "R10");
    endtask

    task automatic t_restart();
        load(0, mw(3'b011, 0, 3'b010, 0));
        burst_start = 1; burst_is_write = 0; start_col = 10'h10;
        tick(); burst_start = 0;
        tick(); tick();
        chk(int'(col_out) == 10'h12, "R7", "beat 2", col_out, 10'h12);
        burst_stop = 1;
        run_burst(10'h25, 1, 8, 0, 1, "R11");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_wr = 0; mode_sel = 0; mode_data = '0;
        burst_start = 0; burst_is_write = 0; start_col = '0; burst_stop = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_lengths();
        t_order();
        t_cas_dll();
        t_illegal();
        t_stop();
        t_restart();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule